// File: doc/BRIEF.md
# Serial Clock Divider with Programmable Duty

This block produces the serial clock for a serial-peripheral sequencer from a fast base clock. An integer divisor sets the period in base cycles. An 8-bit duty code sets how much of each period is spent in the active phase, in steps of 1/256 of the period. Two strobes, each one base cycle wide, tell the sequencer when the serial clock has just risen and when it has just fallen. The sequencer uses them to launch outgoing bits and to sample incoming bits without running logic on the serial clock itself.

A four-state machine drives the block. The states are `ST_IDLE`, `ST_LEAD`, `ST_TRAIL` and `ST_BYPASS`.
- `ST_IDLE` moves to `ST_LEAD` on *start*. Start is enable seen while idle with an effective divisor of at least 2.
- `ST_IDLE` moves to `ST_BYPASS` on *start-bypass*. This is enable seen while idle with an effective divisor of 1.
- `ST_LEAD` moves to `ST_TRAIL` on *lead-done*, after the programmed high count has elapsed.
- From `ST_TRAIL`, the end of the period leads to one of three states. It goes back to `ST_LEAD` on *wrap* when enable is still set. It goes to `ST_BYPASS` on *wrap-bypass* when enable is set and the new divisor is 1. It goes to `ST_IDLE` on *stop* when enable has been cleared.
- `ST_BYPASS` moves to `ST_IDLE` on *leave-bypass* once enable is cleared.

The divisor and the duty code are captured at the start of every period. Each period therefore runs to completion with the settings it began with.

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is held, and in `ST_IDLE`, `sclk` equals the `cpol` input and both strobes are 0.
- R2: For an effective divisor n ≥ 2, every period lasts exactly n base cycles. The active phase (sclk = not cpol) comes first and the idle-level phase follows.
- R3: For n ≥ 2 the active phase lasts h = floor((n·d + 128) / 256) base cycles, where d is the effective duty code. If that gives 0, h is 1. If it gives n or more, h is n−1.
- R4: A duty code of 0 produces the same waveform as a duty code of 128.
- R5: The idle level is `cpol`. With `cpol` = 0 each period starts with a rising edge. With `cpol` = 1 each period starts with a falling edge.
- R6: `rise_stb` is 1 for exactly the base cycle in which `sclk` has just gone from 0 to 1. `fall_stb` is 1 for exactly the base cycle in which `sclk` has just gone from 1 to 0. Outside bypass, the two strobes are never 1 together.
- R7: A divisor of 1 or 0 selects bypass. `sclk` then equals the base clock XOR `cpol`, and both strobes are held at 1 until enable is cleared. At the next edge after that, the block returns to idle.
- R8: Enable seen at a clock edge while idle starts a full period. `sclk` takes the active level in the cycle after that edge, so no shortened first pulse occurs.
- R9: Clearing enable in the middle of a period lets that period finish in full. The block then returns to idle.
- R10: Changes to divisor or duty made in the middle of a period take effect only from the next period.
- R11: While idle, changes to divisor or duty have no effect on `sclk` or on the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run request |
| cpol | input | 1 | Idle level of the serial clock |
| div | input | DIV_W | Period in base cycles (0 and 1 both mean bypass) |
| duty | input | 8 | Active-phase fraction in 1/256 steps (0 means 128) |
| sclk | output | 1 | Serial clock |
| rise_stb | output | 1 | One-cycle pulse when sclk has just risen |
| fall_stb | output | 1 | One-cycle pulse when sclk has just fallen |

## Verification
The bench checks the extremes of the high-time rounding:
- a duty near full scale, which must be clamped to n−1 rather than leaving no idle phase;
- a duty near zero, which must be raised to 1 rather than leaving no pulse;
- a duty code of 0, which must not be read literally as a 0 % duty.

It clears enable in the middle of a period and expects that period to finish in full. A design that stopped at once would produce a runt pulse. It changes the divisor in the middle of a period and expects the new value only from the next period. A design that used the new value at once would stretch or cut the running period. It drives divisors of 1 and 0 and checks that the base clock is passed through with both strobes held high. It also checks the strobe polarity for each `cpol` setting, since a swapped polarity would make the sequencer launch data on the wrong edge.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

    // Control states of the serial clock generator.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEAD   = 2'd1,
        ST_TRAIL  = 2'd2,
        ST_BYPASS = 2'd3
    } sclk_state_e;

    // Duty resolution: high time is expressed in 1/(2**FRAC_W) of a period.
    localparam int FRAC_W    = 8;
    localparam int DUTY_HALF = 1 << (FRAC_W - 1);

endpackage

// File: rtl/spi_sclk_hightime.sv
// Turns the raw divisor and duty code into an effective period, a clamped
// high count and a bypass flag. Purely combinational.
module spi_sclk_hightime #(
    parameter int DIV_W  = 8,
    parameter int FRAC_W = 8
) (
    input  logic [DIV_W-1:0]  div,
    input  logic [FRAC_W-1:0] duty,
    output logic [DIV_W-1:0]  period,
    output logic [DIV_W-1:0]  high_cyc,
    output logic              bypass
);
    localparam int PW   = DIV_W + FRAC_W;
    localparam int HALF = 1 << (FRAC_W - 1);

    logic [DIV_W-1:0]  eff_div;
    logic [FRAC_W-1:0] eff_duty;
    logic [PW-1:0]     prod;
    logic [PW-1:0]     rounded;
    logic [DIV_W-1:0]  raw_high;

    always_comb begin
        eff_div  = (div == '0) ? DIV_W'(1) : div;
        eff_duty = (duty == '0) ? FRAC_W'(HALF) : duty;
        prod     = PW'(eff_div) * PW'(eff_duty);
        rounded  = prod + PW'(HALF);
        raw_high = rounded[PW-1:FRAC_W];

        if (raw_high == '0) begin
            high_cyc = DIV_W'(1);
        end else if (raw_high >= eff_div) begin
            high_cyc = eff_div - DIV_W'(1);
        end else begin
            high_cyc = raw_high;
        end

        period = eff_div;
        bypass = (eff_div == DIV_W'(1));
    end
endmodule

// File: rtl/spi_sclk_phase_cnt.sv
// Base-cycle position counter within one serial clock period.
module spi_sclk_phase_cnt #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [DIV_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/spi_sclk_gen.sv
// Serial clock generator: integer division of the base clock, duty in
// 1/256 steps, edge strobes for the sequencer, graceful start and stop.
module spi_sclk_gen
    import spi_sclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cpol,
    input  logic [DIV_W-1:0]  div,
    input  logic [FRAC_W-1:0] duty,
    output logic              sclk,
    output logic              rise_stb,
    output logic              fall_stb
);
    sclk_state_e      state_q, state_d;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] n_q, h_q;
    logic             pol_q, pol_d;
    logic             sclk_q, rise_q, fall_q;

    logic [DIV_W-1:0] cfg_period, cfg_high;
    logic             cfg_bypass;
    logic             lead_done, period_done, load, running, cnt_clear;

    spi_sclk_hightime #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_hightime (
        .div      (div),
        .duty     (duty),
        .period   (cfg_period),
        .high_cyc (cfg_high),
        .bypass   (cfg_bypass)
    );

    assign running     = (state_q == ST_LEAD) || (state_q == ST_TRAIL);
    assign lead_done   = (cnt_q == h_q - DIV_W'(1));
    assign period_done = (cnt_q == n_q - DIV_W'(1));
    assign load        = en && ((state_q == ST_IDLE) ||
                                ((state_q == ST_TRAIL) && period_done));
    assign cnt_clear   = load || !running;

    spi_sclk_phase_cnt #(.DIV_W(DIV_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .cnt   (cnt_q)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en) state_d = cfg_bypass ? ST_BYPASS : ST_LEAD;
            end
            ST_LEAD: begin
                if (lead_done) state_d = ST_TRAIL;
            end
            ST_TRAIL: begin
                if (period_done) begin
                    if (!en)             state_d = ST_IDLE;
                    else if (cfg_bypass) state_d = ST_BYPASS;
                    else                 state_d = ST_LEAD;
                end
            end
            ST_BYPASS: begin
                if (!en) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign pol_d = load ? cpol : pol_q;

    // State register and per-period configuration snapshot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            n_q     <= DIV_W'(2);
            h_q     <= DIV_W'(1);
            pol_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                n_q   <= cfg_period;
                h_q   <= cfg_high;
                pol_q <= cpol;
            end
        end
    end

    // Output registers, decoded from the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            unique case (state_d)
                ST_LEAD: begin
                    sclk_q <= ~pol_d;
                    rise_q <= (state_q != ST_LEAD) && !pol_d;
                    fall_q <= (state_q != ST_LEAD) &&  pol_d;
                end
                ST_TRAIL: begin
                    sclk_q <= pol_d;
                    rise_q <= (state_q != ST_TRAIL) &&  pol_d;
                    fall_q <= (state_q != ST_TRAIL) && !pol_d;
                end
                ST_BYPASS: begin
                    sclk_q <= pol_d;
                    rise_q <= 1'b1;
                    fall_q <= 1'b1;
                end
                default: begin
                    sclk_q <= pol_d;
                    rise_q <= 1'b0;
                    fall_q <= 1'b0;
                end
            endcase
        end
    end

    // Serial clock select: pass-through in bypass, live idle level when idle.
    always_comb begin
        unique case (state_q)
            ST_BYPASS: sclk = clk ^ pol_q;
            ST_IDLE:   sclk = cpol;
            default:   sclk = sclk_q;
        endcase
    end

    assign rise_stb = rise_q;
    assign fall_stb = fall_q;

endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk
    import spi_sclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input sclk_state_e      state,
    input logic [DIV_W-1:0] cnt,
    input logic [DIV_W-1:0] n_q,
    input logic [DIV_W-1:0] h_q,
    input logic             sclk,
    input logic             rise_stb,
    input logic             fall_stb
);
    logic run;
    assign run = (state == ST_LEAD) || (state == ST_TRAIL);

    assert_high_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (h_q != '0) && (h_q < n_q));

    assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt < n_q);

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != '0) |-> ($stable(n_q) && $stable(h_q)));

    assert_rise_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_stb && state != ST_BYPASS) |-> (sclk && !$past(sclk)));

    assert_fall_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_stb && state != ST_BYPASS) |-> (!sclk && $past(sclk)));

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !(rise_stb && fall_stb));

    assert_bypass_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BYPASS) |-> (rise_stb && fall_stb));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!rise_stb && !fall_stb));

    assert_full_period_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state == ST_TRAIL) && state == ST_IDLE) |->
            ($past(cnt) == $past(n_q) - DIV_W'(1)));
endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .cnt      (cnt_q),
    .n_q      (n_q),
    .h_q      (h_q),
    .sclk     (sclk),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
);

// File: tb/tb_spi_sclk_gen.sv
`timescale 1ns/1ps
module tb_spi_sclk_gen;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             cpol = 1'b0;
    logic [DIV_W-1:0] div = '0;
    logic [7:0]       duty = '0;
    logic             sclk, rise_stb, fall_stb;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    spi_sclk_gen #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol),
        .div(div), .duty(duty),
        .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int exp_high(input int n, input int d);
        int dd, h;
        dd = (d == 0) ? 128 : d;
        h  = (n * dd + 128) / 256;
        if (h < 1) h = 1;
        if (h > n - 1) h = n - 1;
        return h;
    endfunction

    task automatic check_idle(input string req, input bit pol, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk); #1;
            chk(req, "idle sclk", sclk, pol);
            chk(req, "idle rise", rise_stb, 0);
            chk(req, "idle fall", fall_stb, 0);
        end
    endtask

    // Run whole periods from idle and compare every base cycle.
    task automatic run_pattern(input int n, input int d, input bit pol,
                               input int periods, input string req);
        int h, ph;
        h = exp_high(n, d);
        @(negedge clk);
        div = DIV_W'(n); duty = 8'(d); cpol = pol; en = 1'b1;
        for (int k = 0; k < n * periods; k++) begin
            @(negedge clk); #1;
            ph = k % n;
            chk(req, "sclk", sclk, (ph < h) ? int'(!pol) : int'(pol));
            chk(req, "rise", rise_stb, pol ? int'(ph == h) : int'(ph == 0));
            chk(req, "fall", fall_stb, pol ? int'(ph == 0) : int'(ph == h));
        end
        en = 1'b0;
        check_idle("R9", pol, 2);
    endtask

    // Clear enable early in a period: the period must still complete (R9).
    task automatic t_graceful_stop();
        @(negedge clk);
        div = 8; duty = 0; cpol = 0; en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); #1;
            chk("R9", "sclk during drain", sclk, (k < 4) ? 1 : 0);
            if (k == 2) en = 1'b0;
        end
        check_idle("R9", 0, 3);
    endtask

    // Change the divisor mid-period: old period completes, new one follows (R10).
    task automatic t_midchange();
        @(negedge clk);
        div = 4; duty = 0; cpol = 0; en = 1'b1;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk); #1;
            if (k < 4) chk("R10", "old period sclk", sclk, (k < 2) ? 1 : 0);
            else       chk("R10", "new period sclk", sclk, (((k - 4) % 6) < 3) ? 1 : 0);
            if (k == 1) div = 6;
        end
        en = 1'b0;
        check_idle("R10", 0, 2);
    endtask

    // Idle: config changes must not move outputs (R11, R1 follows live cpol).
    task automatic t_idle_config();
        @(negedge clk);
        en = 1'b0; cpol = 1'b1;
        for (int i = 0; i < 4; i++) begin
            div = DIV_W'(2 + 3 * i); duty = 8'(40 * i + 7);
            @(negedge clk); #1;
            chk("R11", "idle sclk", sclk, 1);
            chk("R11", "idle rise", rise_stb, 0);
            chk("R11", "idle fall", fall_stb, 0);
        end
        cpol = 1'b0;
        @(negedge clk); #1;
        chk("R1", "idle level follows cpol", sclk, 0);
    endtask

    // Divisor 1 or 0: pass-through clock, strobes held (R7).
    task automatic t_bypass(input int dv, input bit pol);
        @(negedge clk);
        div = DIV_W'(dv); duty = 0; cpol = pol; en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #5;
            chk("R7", "bypass sclk clk high", sclk, int'(!pol));
            chk("R7", "bypass rise", rise_stb, 1);
            chk("R7", "bypass fall", fall_stb, 1);
            @(negedge clk); #5;
            chk("R7", "bypass sclk clk low", sclk, int'(pol));
        end
        en = 1'b0;
        @(posedge clk); #5;
        chk("R7", "left bypass sclk", sclk, int'(pol));
        chk("R7", "left bypass rise", rise_stb, 0);
        chk("R7", "left bypass fall", fall_stb, 0);
        @(negedge clk); #5;
        chk("R7", "left bypass sclk low phase", sclk, int'(pol));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset sclk", sclk, 0);
        chk("R1", "reset rise", rise_stb, 0);
        chk("R1", "reset fall", fall_stb, 0);
        rst_n = 1'b1;
        check_idle("R1", 0, 2);

        run_pattern(2,   0, 0, 3, "R2");
        run_pattern(3, 128, 0, 2, "R3");
        run_pattern(10, 64, 0, 2, "R3");
        run_pattern(5, 255, 0, 2, "R3");   // rounds to 5, clamped to 4
        run_pattern(5,   1, 0, 2, "R3");   // rounds to 0, raised to 1
        run_pattern(7,   0, 0, 2, "R4");
        run_pattern(7, 128, 0, 2, "R4");
        run_pattern(4,   0, 1, 3, "R5");
        run_pattern(9, 200, 1, 2, "R6");
        run_pattern(6,  90, 0, 1, "R8");
        t_graceful_stop();
        t_midchange();
        t_idle_config();
        t_bypass(1, 0);
        t_bypass(0, 1);
        run_pattern(3,   0, 0, 2, "R8");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule